// File: doc/BRIEF.md
# Rate-Switchable Puncturer and Depuncturer

This block sits around a rate 1/2, single-input convolutional encoder and its decoder. On the transmit side it collects the two-bit symbols from two consecutive encoder steps into a four-bit group. It then sends the group to the channel one bit at a time and leaves out every position whose keep-mask bit is clear. A full mask passes the mother code through at rate 1/2. A mask that drops the third bit of each group sends three channel bits for every two data bits, which gives rate 2/3.

On the receive side the reduced channel stream is expanded back into four-bit groups. Each output bit carries an erasure flag. Positions that were sent forward the next received bit with the flag clear. Positions that were dropped produce a value of 0 with the flag set, so the decoder can give them no weight in its branch metric. Both masks are inputs that can be changed at run time. Each side samples its mask only at the start of a group, so a group is never split between two patterns.

All four stream edges use valid/ready handshakes. Back-pressure on either side stalls the stream without losing or repeating a bit.

Top module: `punct_pair`

## Requirements
- R1: After reset the transmit side is ready for a symbol and shows no valid channel bit. The receive side starts at group position 0.
- R2: Group bit 2*s+b is bit b of the s-th symbol of the group (s = 0 is the first symbol accepted). Kept bits leave in ascending position order, and the channel bit is the grouped data bit at that position.
- R3: With transmit mask 4'b1111, all four group bits are sent, which is rate 1/2.
- R4: With transmit mask 4'b1011, position 2 is never sent, so each two-symbol group yields exactly three channel bits.
- R5: The transmit mask is sampled when the first symbol of a group is accepted. Later changes within that group have no effect on which bits are sent.
- R6: With transmit mask 4'b0000, a group is taken in and discarded, and no channel bit is produced.
- R7: While a channel bit is offered and not accepted, it stays valid and unchanged. No symbol is accepted while a group is being sent.
- R8: At a position whose receive-mask bit is set, the next received bit is forwarded with the erasure flag 0, and exactly one received bit is consumed.
- R9: At a position whose receive-mask bit is clear, the output is valid with value 0 and erasure flag 1, and no received bit is consumed.
- R10: The receive mask is sampled at the transfer of group position 0. Changes at positions 1 to 3 are ignored.
- R11: While the downstream is not ready, the receive side accepts no channel bit.
- R12: With the channel looped back and the same mask on both sides, every non-erased output bit equals the encoder bit at that group position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_mask_i | input | 4 | Transmit keep mask, bit i keeps group position i |
| enc_valid_i | input | 1 | Encoder symbol valid |
| enc_sym_i | input | 2 | Encoder symbol from one encoder step |
| enc_ready_o | output | 1 | Symbol accepted when high with valid |
| ch_valid_o | output | 1 | Channel bit valid |
| ch_bit_o | output | 1 | Channel bit |
| ch_ready_i | input | 1 | Channel accepts the bit |
| rx_mask_i | input | 4 | Receive keep mask, same encoding as the transmit mask |
| rx_valid_i | input | 1 | Received channel bit valid |
| rx_bit_i | input | 1 | Received channel bit |
| rx_ready_o | output | 1 | Received bit consumed when high with valid |
| dp_valid_o | output | 1 | Restored bit valid |
| dp_bit_o | output | 1 | Restored bit, 0 at erased positions |
| dp_erase_o | output | 1 | Erasure flag for the restored bit |
| dp_ready_i | input | 1 | Decoder accepts the restored bit |

## Verification
The properties assume that the channel and the decoder follow the handshake, with ready free to drop at any cycle. They also assume that the received stream is aligned so that its first bit belongs to group position 0. The bench changes a mask only at positions where the mask is not sampled, so that R5 and R10 can be checked. It stops the downstream ready exactly at a group end before it loads a new receive mask. This keeps all-erasure patterns, which produce output with no input, in step with the expected position count. Ready on both outputs is toggled at random, and received bits arrive with random gaps, so stalls fall at every group position.

// File: rtl/punct_pkg.sv
package punct_pkg;
  localparam int unsigned MAX_GRP = 32;

  // lowest set mask position at or above from; width when none
  function automatic int unsigned next_kept(input logic [MAX_GRP-1:0] mask,
                                            input int unsigned from,
                                            input int unsigned width);
    int unsigned res;
    res = width;
    for (int unsigned i = MAX_GRP; i > 0; i--) begin
      if ((i - 1) >= from && (i - 1) < width && mask[i-1]) res = i - 1;
    end
    return res;
  endfunction
endpackage

// File: rtl/punct_tx.sv
module punct_tx #(
  parameter int unsigned SYM_W    = 2,
  parameter int unsigned GRP_SYMS = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [SYM_W*GRP_SYMS-1:0] mask_i,
  input  logic                      sym_valid_i,
  input  logic [SYM_W-1:0]          sym_i,
  output logic                      sym_ready_o,
  output logic                      bit_valid_o,
  output logic                      bit_o,
  input  logic                      bit_ready_i
);
  import punct_pkg::*;

  localparam int unsigned GRP_W  = SYM_W * GRP_SYMS;
  localparam int unsigned POS_W  = $clog2(GRP_W + 1);
  localparam int unsigned IDX_W  = (GRP_W > 1) ? $clog2(GRP_W) : 1;
  localparam int unsigned FILL_W = $clog2(GRP_SYMS + 1);

  logic [GRP_W-1:0]  grp_q, mask_q, eff_mask;
  logic [FILL_W-1:0] fill_q;
  logic [POS_W-1:0]  pos_q, first_pos, next_pos;
  logic [IDX_W-1:0]  pos_idx;
  logic              emit, last_sym, sym_fire, bit_fire;

  assign emit        = (fill_q == FILL_W'(GRP_SYMS));
  assign last_sym    = (fill_q == FILL_W'(GRP_SYMS - 1));
  assign sym_ready_o = !emit;
  assign sym_fire    = sym_valid_i && sym_ready_o;
  assign bit_valid_o = emit && (pos_q < POS_W'(GRP_W));
  assign bit_fire    = bit_valid_o && bit_ready_i;
  assign pos_idx     = pos_q[IDX_W-1:0];
  assign bit_o       = bit_valid_o ? grp_q[pos_idx] : 1'b0;
  // mask of the group is the live input until its first symbol lands
  assign eff_mask    = (fill_q == '0) ? mask_i : mask_q;

  always_comb begin
    first_pos = POS_W'(next_kept(MAX_GRP'(eff_mask), 0, GRP_W));
    next_pos  = POS_W'(next_kept(MAX_GRP'(mask_q), int'(pos_q) + 1, GRP_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q  <= '0;
      mask_q <= '0;
      fill_q <= '0;
      pos_q  <= '0;
    end else if (sym_fire) begin
      grp_q[int'(fill_q)*SYM_W +: SYM_W] <= sym_i;
      if (fill_q == '0) mask_q <= mask_i;
      fill_q <= fill_q + 1'b1;
      if (last_sym) pos_q <= first_pos;
    end else if (emit) begin
      if (bit_fire) begin
        pos_q <= next_pos;
        if (next_pos == POS_W'(GRP_W)) fill_q <= '0;
      end else if (pos_q == POS_W'(GRP_W)) begin
        fill_q <= '0;  // empty pattern: group dropped
      end
    end
  end
endmodule

// File: rtl/punct_rx.sv
module punct_rx #(
  parameter int unsigned GRP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] mask_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic             bit_ready_o,
  output logic             out_valid_o,
  output logic             out_bit_o,
  output logic             out_erase_o,
  input  logic             out_ready_i
);
  localparam int unsigned IDX_W = (GRP_W > 1) ? $clog2(GRP_W) : 1;

  logic [IDX_W-1:0] pos_q;
  logic [GRP_W-1:0] mask_q, eff_mask;
  logic             keep, out_fire, at_start, at_end;

  assign at_start    = (pos_q == '0);
  assign at_end      = (pos_q == IDX_W'(GRP_W - 1));
  assign eff_mask    = at_start ? mask_i : mask_q;
  assign keep        = eff_mask[pos_q];
  assign out_valid_o = keep ? bit_valid_i : 1'b1;
  assign out_bit_o   = keep & bit_i;
  assign out_erase_o = !keep;
  assign bit_ready_o = keep & out_ready_i;
  assign out_fire    = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      mask_q <= '0;
    end else if (out_fire) begin
      if (at_start) mask_q <= mask_i;
      pos_q <= at_end ? '0 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/punct_pair.sv
module punct_pair #(
  parameter int unsigned SYM_W    = 2,
  parameter int unsigned GRP_SYMS = 2,
  localparam int unsigned GRP_W   = SYM_W * GRP_SYMS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] tx_mask_i,
  input  logic             enc_valid_i,
  input  logic [SYM_W-1:0] enc_sym_i,
  output logic             enc_ready_o,
  output logic             ch_valid_o,
  output logic             ch_bit_o,
  input  logic             ch_ready_i,
  input  logic [GRP_W-1:0] rx_mask_i,
  input  logic             rx_valid_i,
  input  logic             rx_bit_i,
  output logic             rx_ready_o,
  output logic             dp_valid_o,
  output logic             dp_bit_o,
  output logic             dp_erase_o,
  input  logic             dp_ready_i
);
  punct_tx #(.SYM_W(SYM_W), .GRP_SYMS(GRP_SYMS)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_i      (tx_mask_i),
    .sym_valid_i (enc_valid_i),
    .sym_i       (enc_sym_i),
    .sym_ready_o (enc_ready_o),
    .bit_valid_o (ch_valid_o),
    .bit_o       (ch_bit_o),
    .bit_ready_i (ch_ready_i)
  );

  punct_rx #(.GRP_W(GRP_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_i      (rx_mask_i),
    .bit_valid_i (rx_valid_i),
    .bit_i       (rx_bit_i),
    .bit_ready_o (rx_ready_o),
    .out_valid_o (dp_valid_o),
    .out_bit_o   (dp_bit_o),
    .out_erase_o (dp_erase_o),
    .out_ready_i (dp_ready_i)
  );
endmodule

// File: rtl/punct_pair_chk.sv
module punct_pair_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enc_ready_o,
  input logic ch_valid_o,
  input logic ch_bit_o,
  input logic ch_ready_i,
  input logic rx_valid_i,
  input logic rx_bit_i,
  input logic rx_ready_o,
  input logic dp_valid_o,
  input logic dp_bit_o,
  input logic dp_erase_o,
  input logic dp_ready_i
);
  // R7
  ch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_valid_o && !ch_ready_i |=> ch_valid_o && $stable(ch_bit_o));

  // R7
  tx_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(enc_ready_o && ch_valid_o));

  // R8
  rx_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o && rx_valid_i |-> dp_valid_o && !dp_erase_o && (dp_bit_o == rx_bit_i));

  // R9
  erase_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_valid_o && dp_erase_o |-> !dp_bit_o && !rx_ready_o);

  // R11
  rx_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dp_ready_i |-> !rx_ready_o);
endmodule

bind punct_pair punct_pair_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enc_ready_o(enc_ready_o),
  .ch_valid_o (ch_valid_o),
  .ch_bit_o   (ch_bit_o),
  .ch_ready_i (ch_ready_i),
  .rx_valid_i (rx_valid_i),
  .rx_bit_i   (rx_bit_i),
  .rx_ready_o (rx_ready_o),
  .dp_valid_o (dp_valid_o),
  .dp_bit_o   (dp_bit_o),
  .dp_erase_o (dp_erase_o),
  .dp_ready_i (dp_ready_i)
);

// File: tb/sim_punct_pair.sv
module sim_punct_pair;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] tx_mask_i = 4'hF;
  logic       enc_valid_i = 1'b0;
  logic [1:0] enc_sym_i = '0;
  logic       enc_ready_o, ch_valid_o, ch_bit_o, ch_ready_i;
  logic [3:0] rx_mask_i = 4'hF;
  logic       rx_valid_i, rx_bit_i, rx_ready_o;
  logic       dp_valid_o, dp_bit_o, dp_erase_o;
  logic       dp_ready_i = 1'b0;

  logic ch_ready_drv = 1'b1, rx_valid_drv = 1'b0, rx_bit_drv = 1'b0;
  bit   loop = 1'b0, tx_stall = 1'b0;
  bit   rx_scr = 1'b0;
  logic [3:0] rm = 4'hF;
  int   grp_left = 0, rpos = 0, tx_cnt = 0;
  int   total = 0, bad = 0;
  string tx_req = "R2";
  bit   txq[$], encq[$], rxq[$];

  assign ch_ready_i = loop ? rx_ready_o : ch_ready_drv;
  assign rx_valid_i = loop ? ch_valid_o : rx_valid_drv;
  assign rx_bit_i   = loop ? ch_bit_o   : rx_bit_drv;

  punct_pair u0 (.*, .clk_i(clk));

  initial forever #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // ready drivers
  initial forever begin
    @(posedge clk); #1;
    ch_ready_drv = tx_stall ? ($urandom_range(0, 2) != 0) : 1'b1;
    dp_ready_i   = (grp_left > 0) ? ($urandom_range(0, 3) != 0) : 1'b0;
  end

  // channel monitor
  initial begin
    bit held = 0, held_bit = 0;
    forever begin
      @(negedge clk);
      if (held) chk(ch_valid_o && ch_bit_o == held_bit, "R7", ch_bit_o, held_bit);
      held = ch_valid_o && !ch_ready_i;
      held_bit = ch_bit_o;
      if (ch_valid_o && ch_ready_i) begin
        tx_cnt++;
        if (txq.size() == 0) chk(0, "R6", 1, 0);
        else begin
          bit e;
          e = txq.pop_front();
          chk(ch_bit_o == e, tx_req, ch_bit_o, e);
        end
      end
    end
  end

  // restored-stream monitor
  initial forever begin
    bit fired;
    fired = 0;
    @(negedge clk);
    if (!dp_ready_i) chk(!rx_ready_o, "R11", rx_ready_o, 0);
    if (dp_valid_o && dp_ready_i) begin
      bit kp, e;
      fired = 1;
      kp = rm[rpos];
      e = 0;
      if (loop) begin
        if (encq.size() > 0) e = encq.pop_front();
        else chk(0, "R12", 1, 0);
      end else if (kp) begin
        if (rxq.size() > 0) e = rxq.pop_front();
        else chk(0, "R8", 1, 0);
      end
      if (!kp) e = 0;
      chk(dp_bit_o == e && dp_erase_o == !kp,
          loop ? "R12" : (kp ? "R8" : "R9"), {dp_erase_o, dp_bit_o}, {!kp, e});
      rpos = (rpos + 1) % 4;
      if (rpos == 0) grp_left--;
    end
    @(posedge clk); #1;
    if (fired) begin
      if (rpos == 0) rx_mask_i = rm;
      else if (rx_scr) rx_mask_i = ~rm;  // R10: ignored mid-group
    end
  end

  task automatic send_group(input logic [3:0] m, input logic [3:0] g, input bit scr);
    tx_mask_i = m;
    for (int s = 0; s < 2; s++) begin
      enc_valid_i = 1'b1;
      enc_sym_i = g[2*s +: 2];
      do @(negedge clk); while (!enc_ready_o);
      @(posedge clk); #1;
      enc_valid_i = 1'b0;
      if (scr) tx_mask_i = ~m;  // R5: ignored after group start
    end
    for (int p = 0; p < 4; p++) if (m[p]) txq.push_back(g[p]);
  endtask

  task automatic feed_rx(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(0, 2) == 0) begin
        rx_valid_drv = 1'b0;
        @(posedge clk); #1;
      end
      rx_bit_drv = 1'($urandom_range(0, 1));
      rxq.push_back(rx_bit_drv);
      rx_valid_drv = 1'b1;
      do @(negedge clk); while (!rx_ready_o);
      @(posedge clk); #1;
      rx_valid_drv = 1'b0;
    end
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((grp_left > 0 || txq.size() > 0) && guard < 2000) begin
      @(posedge clk); #1;
      guard++;
    end
    repeat (8) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(enc_ready_o == 1'b1, "R1", enc_ready_o, 1);
    chk(ch_valid_o == 1'b0, "R1", ch_valid_o, 0);
    chk(dp_valid_o == 1'b0, "R1", dp_valid_o, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk(enc_ready_o == 1'b1 && ch_valid_o == 1'b0, "R1", ch_valid_o, 0);

    // transmit sweep over every mask, mask scrambled after group start
    tx_stall = 1'b1;
    for (int m = 0; m < 16; m++) begin
      tx_req = (m == 15) ? "R3" : (m == 11) ? "R4" : "R5";
      tx_cnt = 0;
      for (int g = 0; g < 6; g++) send_group(4'(m), 4'($urandom_range(0, 15)), 1'b1);
      drain();
      chk(txq.size() == 0, tx_req, txq.size(), 0);
      chk(tx_cnt == 6 * $countones(4'(m)), (m == 0) ? "R6" : (m == 11) ? "R4" : "R2",
          tx_cnt, 6 * $countones(4'(m)));
    end
    tx_stall = 1'b0;

    // receive sweep over every mask, mask scrambled mid-group
    rx_scr = 1'b1;
    for (int m = 0; m < 16; m++) begin
      rm = 4'(m);
      rx_mask_i = rm;
      grp_left = 6;
      feed_rx(6 * $countones(4'(m)));
      drain();
      chk(grp_left == 0 && rxq.size() == 0, "R10", grp_left, 0);
    end
    rx_scr = 1'b0;

    // loop-back with matching masks
    loop = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic [3:0] m;
      logic [3:0] gd [4];
      m = (k == 0) ? 4'b1111 : (k == 1) ? 4'b1011 : (k == 2) ? 4'b0110 : 4'b0000;
      tx_req = "R12";
      rm = m;
      rx_mask_i = m;
      for (int g = 0; g < 4; g++) begin
        gd[g] = 4'($urandom_range(0, 15));
        for (int p = 0; p < 4; p++) encq.push_back(gd[g][p]);
      end
      grp_left = 4;
      for (int g = 0; g < 4; g++) send_group(m, gd[g], 1'b0);
      drain();
      chk(encq.size() == 0 && txq.size() == 0, "R12", encq.size(), 0);
    end
    loop = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule